// File: doc/BRIEF.md
# DRAM Address Multiplexer with Refresh Row Counter

This block sits between an 8-bit microprocessor bus and a bank of 64K×1 dynamic RAMs. A 16-bit processor address leaves the block as two 8-bit halves on one shared DRAM address bus. The half that forms the row address is driven while the row strobe falls. One clock later the select moves to the column half, and the column strobe follows one clock after that. Ordinary memory reads and writes therefore run as row-then-column accesses that are paced by the memory-request strobe.

The block also keeps a copy of the processor's refresh register. Its low seven bits step once per opcode fetch and wrap from 127 to 0, while its top bit is held. During a refresh machine cycle the block shows this register on the address bus as a row address, keeps the column strobe inactive and blocks the write enable. This gives a row-only refresh. Software can write the whole register through a load input, and that load is the only way to change the top bit.

Top module: `dram_addr_mux`

## Requirements
- R1: Outside a cycle, and in the row phase of a non-refresh cycle, `dram_addr` equals `cpu_addr[7:0]` (low byte is the row address).
- R2: In a non-refresh cycle, from the first rising edge after `ras_n` fell until the cycle ends, `dram_addr` equals `cpu_addr[15:8]`.
- R3: `ras_n` goes low at the first rising edge that samples `mreq_n` low and stays low while `mreq_n` stays low. At the first edge that samples `mreq_n` high, `ras_n`, `cas_n` and `we_n` all return high.
- R4: `cas_n` goes low no earlier than two edges after `ras_n` fell. It goes low only when `rd_n` or `wr_n` is sampled low and the cycle is not a refresh cycle. It is never low while `ras_n` is high.
- R5: A cycle is a refresh cycle when `rfsh_n` is low at the edge where `ras_n` falls. For the whole of that cycle `dram_addr` shows the refresh register and `cas_n` stays high.
- R6: At each edge that samples `m1_n` low after the previous edge sampled it high, bits 6..0 of the refresh register increase by one and wrap from 127 to 0. Bit 7 is left unchanged.
- R7: `we_n` is low only in the clock after an edge that samples `mreq_n` and `wr_n` low, `rfsh_n` high, and the cycle not latched as refresh. Whenever `rfsh_n` is sampled low, `we_n` is high on the next clock.
- R8: `r_load` high at an edge writes all 8 bits of `r_load_val` into the refresh register, and it takes priority over a fetch increment at the same edge. It is the only way bit 7 can change.
- R9: While `rst_n` is low, all strobes are high and the refresh register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | Processor address |
| mreq_n | input | 1 | Memory request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch indicator, active low |
| rfsh_n | input | 1 | Refresh machine cycle, active low |
| r_load | input | 1 | Write the refresh register |
| r_load_val | input | 8 | Value written by `r_load` |
| dram_addr | output | 8 | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
A wrong refresh register value cannot be seen at the ports until the next refresh cycle, when it is shown on `dram_addr` one edge after `mreq_n` falls. A lost wrap or a changed top bit therefore shows up within one fetch. A sequencer that latched the refresh flag wrongly shows up within two edges of the row strobe falling: it either switches to the column half when it should not, or it pulses `cas_n` or `we_n` in a cycle that should be row-only. The bench replays every stimulus through a behavioural model and compares all four outputs on every clock, so any of these faults is caught in the cycle where it first appears.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

   // Access phase of one memory machine cycle
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ROW  = 2'd1,
      PH_COL  = 2'd2,
      PH_CAS  = 2'd3
   } phase_t;

   function automatic logic phase_is_col(input phase_t ph);
      return (ph == PH_COL) || (ph == PH_CAS);
   endfunction

endpackage

// File: rtl/dmx_refresh_reg.sv
module dmx_refresh_reg #(
   parameter int R_W     = 8,
   parameter int R_CNT_W = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           m1_n,
   input  logic           r_load,
   input  logic [R_W-1:0] r_load_val,
   output logic [R_W-1:0] r_q
);

   localparam logic [R_CNT_W-1:0] CNT_ONE = R_CNT_W'(1);

   logic           m1_d;
   logic           fetch_start;
   logic [R_W-1:0] r_inc;

   // a fetch starts when m1 is seen low after being seen high
   assign fetch_start = m1_d & ~m1_n;

   generate
      if (R_CNT_W == R_W) begin : g_full_count
         assign r_inc = r_q + CNT_ONE;
      end else begin : g_held_top
         logic [R_CNT_W-1:0] cnt_next;
         assign cnt_next = r_q[R_CNT_W-1:0] + CNT_ONE;
         assign r_inc    = {r_q[R_W-1:R_CNT_W], cnt_next};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_q  <= '0;
         m1_d <= 1'b1;
      end else begin
         m1_d <= m1_n;
         if (r_load) begin
            r_q <= r_load_val;
         end else if (fetch_start) begin
            r_q <= r_inc;
         end
      end
   end

endmodule

// File: rtl/dmx_strobe_seq.sv
module dmx_strobe_seq
   import dmx_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic mreq_n,
   input  logic rd_n,
   input  logic wr_n,
   input  logic rfsh_n,
   output logic ras_n,
   output logic cas_n,
   output logic we_n,
   output logic col_sel,
   output logic refr_q
);

   phase_t phase_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         ras_n   <= 1'b1;
         cas_n   <= 1'b1;
         we_n    <= 1'b1;
         refr_q  <= 1'b0;
      end else if (mreq_n) begin
         phase_q <= PH_IDLE;
         ras_n   <= 1'b1;
         cas_n   <= 1'b1;
         we_n    <= 1'b1;
         refr_q  <= 1'b0;
      end else begin
         ras_n <= 1'b0;
         we_n  <= wr_n | ~rfsh_n | refr_q;
         case (phase_q)
            PH_IDLE: begin
               refr_q  <= ~rfsh_n;
               phase_q <= PH_ROW;
            end
            PH_ROW: begin
               if (!refr_q) phase_q <= PH_COL;
            end
            PH_COL: begin
               phase_q <= PH_CAS;
               cas_n   <= rd_n & wr_n;
            end
            PH_CAS: begin
               cas_n <= rd_n & wr_n;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign col_sel = phase_is_col(phase_q);

endmodule

// File: rtl/dmx_addr_sel.sv
module dmx_addr_sel #(
   parameter int ADDR_W     = 16,
   parameter bit ROW_IS_LOW = 1'b1
) (
   input  logic [ADDR_W-1:0]   cpu_addr,
   input  logic [ADDR_W/2-1:0] r_val,
   input  logic                col_sel,
   input  logic                refr,
   output logic [ADDR_W/2-1:0] dram_addr
);

   localparam int HALF_W = ADDR_W / 2;

   logic [HALF_W-1:0] row_half;
   logic [HALF_W-1:0] col_half;

   generate
      if (ROW_IS_LOW) begin : g_row_low
         assign row_half = cpu_addr[HALF_W-1:0];
         assign col_half = cpu_addr[ADDR_W-1:HALF_W];
      end else begin : g_row_high
         assign row_half = cpu_addr[ADDR_W-1:HALF_W];
         assign col_half = cpu_addr[HALF_W-1:0];
      end
   endgenerate

   always_comb begin
      if (col_sel)   dram_addr = col_half;
      else if (refr) dram_addr = r_val;
      else           dram_addr = row_half;
   end

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
   parameter int ADDR_W     = 16,
   parameter int R_W        = 8,
   parameter int R_CNT_W    = 7,
   parameter bit ROW_IS_LOW = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              mreq_n,
   input  logic              rd_n,
   input  logic              wr_n,
   input  logic              m1_n,
   input  logic              rfsh_n,
   input  logic              r_load,
   input  logic [R_W-1:0]    r_load_val,
   output logic [R_W-1:0]    dram_addr,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n
);

   localparam int HALF_W = ADDR_W / 2;

   initial begin
      if (ADDR_W % 2 != 0)
         $fatal(1, "dram_addr_mux: ADDR_W must be even");
      if (R_W != HALF_W)
         $fatal(1, "dram_addr_mux: R_W must equal half the address width");
      if (R_CNT_W < 1 || R_CNT_W > R_W)
         $fatal(1, "dram_addr_mux: R_CNT_W out of range");
   end

   logic [R_W-1:0] r_q;
   logic           col_sel;
   logic           refr_q;

   dmx_refresh_reg #(
      .R_W     (R_W),
      .R_CNT_W (R_CNT_W)
   ) u_rreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .m1_n       (m1_n),
      .r_load     (r_load),
      .r_load_val (r_load_val),
      .r_q        (r_q)
   );

   dmx_strobe_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .mreq_n  (mreq_n),
      .rd_n    (rd_n),
      .wr_n    (wr_n),
      .rfsh_n  (rfsh_n),
      .ras_n   (ras_n),
      .cas_n   (cas_n),
      .we_n    (we_n),
      .col_sel (col_sel),
      .refr_q  (refr_q)
   );

   dmx_addr_sel #(
      .ADDR_W     (ADDR_W),
      .ROW_IS_LOW (ROW_IS_LOW)
   ) u_sel (
      .cpu_addr  (cpu_addr),
      .r_val     (r_q),
      .col_sel   (col_sel),
      .refr      (refr_q),
      .dram_addr (dram_addr)
   );

endmodule

// File: rtl/dram_addr_mux_chk.sv
module dram_addr_mux_chk #(
   parameter int R_W = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           mreq_n,
   input logic           rfsh_n,
   input logic           r_load,
   input logic           ras_n,
   input logic           cas_n,
   input logic           we_n,
   input logic [R_W-1:0] r_val
);

   assert_ras_on_mreq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mreq_n |=> !ras_n);

   assert_release_on_mreq_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mreq_n |=> (ras_n && cas_n && we_n));

   assert_cas_inside_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   assert_refresh_no_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!rfsh_n && !mreq_n && ras_n) |=> cas_n);

   assert_top_bit_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !r_load |=> (r_val[R_W-1] == $past(r_val[R_W-1])));

   assert_we_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rfsh_n |=> we_n);

endmodule

bind dram_addr_mux dram_addr_mux_chk #(.R_W(R_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .mreq_n (mreq_n),
   .rfsh_n (rfsh_n),
   .r_load (r_load),
   .ras_n  (ras_n),
   .cas_n  (cas_n),
   .we_n   (we_n),
   .r_val  (r_q)
);

// File: tb/dram_addr_mux_tb.sv
module dram_addr_mux_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = 16'h0000;
   logic        mreq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1, rfsh_n = 1'b1;
   logic        r_load = 1'b0;
   logic [7:0]  r_load_val = 8'h00;
   logic [7:0]  dram_addr;
   logic        ras_n, cas_n, we_n;

   int n_chk = 0;
   int n_err = 0;
   int cyc   = 0;

   always #4 clk = ~clk;

   dram_addr_mux u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mreq_n(mreq_n),
      .rd_n(rd_n), .wr_n(wr_n), .m1_n(m1_n), .rfsh_n(rfsh_n),
      .r_load(r_load), .r_load_val(r_load_val),
      .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
   );

   // behavioural reference state
   int m_phase = 0;
   int m_r = 0;
   bit m_ras = 1, m_cas = 1, m_we = 1, m_refr = 0, m_m1_prev = 1;

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   always @(posedge clk) begin
      int exp_addr;
      bit new_we;
      cyc++;
      if (!rst_n) begin
         m_phase = 0; m_r = 0; m_ras = 1; m_cas = 1; m_we = 1; m_refr = 0; m_m1_prev = 1;
      end else begin
         if (r_load) m_r = r_load_val;
         else if (m_m1_prev && !m1_n) m_r = (m_r & 8'h80) | ((m_r + 1) & 8'h7F);
         m_m1_prev = m1_n;
         if (mreq_n) begin
            m_phase = 0; m_ras = 1; m_cas = 1; m_we = 1; m_refr = 0;
         end else begin
            new_we = wr_n | !rfsh_n | m_refr;
            m_ras = 0;
            case (m_phase)
               0: begin m_refr = !rfsh_n; m_phase = 1; end
               1: if (!m_refr) m_phase = 2;
               2: begin m_phase = 3; m_cas = rd_n & wr_n; end
               default: m_cas = rd_n & wr_n;
            endcase
            m_we = new_we;
         end
      end
      #2;
      if (m_phase >= 2)  exp_addr = cpu_addr[15:8];
      else if (m_refr)   exp_addr = m_r;
      else               exp_addr = cpu_addr[7:0];
      if (!rst_n) begin
         check("R9 ras_n", ras_n, 1);
         check("R9 cas_n", cas_n, 1);
         check("R9 we_n", we_n, 1);
      end else begin
         check(m_phase >= 2 ? "R2 column addr" : (m_refr ? "R5 refresh addr" : "R1 row addr"),
               dram_addr, exp_addr);
         check("R3 ras_n", ras_n, m_ras);
         check("R4 cas_n", cas_n, m_cas);
         check("R7 we_n", we_n, m_we);
      end
      if (cyc > 100000) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   task automatic idle_bus();
      mreq_n = 1; rd_n = 1; wr_n = 1; m1_n = 1; rfsh_n = 1;
   endtask

   task automatic bus_cycle(input logic [15:0] a, input bit rd, input bit wr,
                            input bit m1, input bit rf, input int n);
      @(negedge clk);
      cpu_addr = a; mreq_n = 0; rd_n = !rd; wr_n = !wr; m1_n = !m1; rfsh_n = !rf;
      repeat (n) @(negedge clk);
      idle_bus();
   endtask

   // opcode fetch then refresh; the refresh row is checked directly
   task automatic fetch(input logic [15:0] pc, input bit ld, input logic [7:0] ld_val,
                        input int exp_row, input string tag);
      @(negedge clk);
      cpu_addr = pc; mreq_n = 0; rd_n = 0; m1_n = 0; r_load = ld; r_load_val = ld_val;
      @(negedge clk);
      r_load = 0;
      repeat (3) @(negedge clk);
      idle_bus();
      @(negedge clk);
      cpu_addr = {8'hC3, 8'h5A}; mreq_n = 0; rfsh_n = 0;
      @(posedge clk); #2;
      check(tag, dram_addr, exp_row);
      check("R5 refresh cas_n", cas_n, 1);
      repeat (2) @(negedge clk);
      idle_bus();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 R2 R4: reads and writes with varied address patterns
      bus_cycle(16'h1234, 1, 0, 0, 0, 4);
      bus_cycle(16'hABCD, 0, 1, 0, 0, 5);
      bus_cycle(16'hFF00, 1, 0, 0, 0, 3);
      bus_cycle(16'h00FF, 0, 1, 0, 0, 2);
      bus_cycle(16'h5AA5, 0, 0, 0, 0, 4);
      // R7: a write strobe during a refresh cycle leaves we_n high
      bus_cycle(16'h7E81, 0, 1, 0, 1, 4);
      // R6: 130 fetches cover the wrap of the low seven bits
      for (int k = 1; k <= 130; k++)
         fetch(16'(k * 3), 0, 8'h00, k & 8'h7F, "R6 refresh row");
      // R8: load sets the top bit; later wraps keep it
      fetch(16'h0100, 1, 8'hFE, 8'hFE, "R8 loaded row");
      fetch(16'h0101, 0, 8'h00, 8'hFF, "R6 top bit held");
      fetch(16'h0102, 0, 8'h00, 8'h80, "R6 wrap keeps bit 7");
      // R8: a load at the fetch edge wins over the increment
      fetch(16'h0103, 1, 8'h55, 8'h55, "R8 load priority");
      bus_cycle(16'h9C3E, 0, 1, 0, 0, 3);
      // R9: reset in the middle of a cycle
      @(negedge clk);
      cpu_addr = 16'h4242; mreq_n = 0; rd_n = 0;
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      idle_bus();
      @(negedge clk);
      rst_n = 1;
      fetch(16'h0200, 0, 8'h00, 8'h01, "R9 register cleared");
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule